// File: doc/BRIEF.md
# ACPI Power Management Timer

This block is a free-running counter that software uses as a fixed-rate time base. A separate tick-enable input paces it, and at the nominal ACPI rate that input is high about 3.58 million times per second. The counter is `CNT_W` bits wide and defaults to 24. Software reads it through one 32-bit register on a small request/acknowledge bus. The register is read-only. Writes are acknowledged and change nothing, and the count is zero-extended to 32 bits. Only full-word accesses are legal. Any access whose byte strobes are not all set is answered with an error flag and zero data.

When the counter's most significant bit changes value, the block emits a one-cycle event pulse. This happens in both directions: from 0 to 1 halfway through the range, and from 1 to 0 when the counter wraps. The pulse sets a sticky timer-status flag, which is the input the PM1 event logic needs. When the event logic's timer-enable bit is high, each pulse also becomes a wake request, and a set status becomes a level interrupt request. A clear strobe from software drops the status. After a clear, the flag re-arms only on the next change of the top bit, so the next event is always measured from the current count.

Top module: `acpi_pm_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `tmr_evt`, `tmr_sts`, `wake_req`, `sci_req`, `bus_ack`, `bus_err` and `bus_rdata` are all zero. The count restarts at zero, so the first read after reset returns the number of ticks seen since reset.
- R2: The count increases by exactly one, modulo 2^CNT_W, at every clock edge where `tick_en` is high. It holds its value at every other edge.
- R3: A request with `bus_we`=0 and `bus_be`=4'hF is answered one cycle later with `bus_ack`=1 and `bus_err`=0. `bus_rdata` then carries the count as it stood at the request edge in bits CNT_W-1:0, and bits 31:CNT_W are zero.
- R4: A request with `bus_we`=1 and `bus_be`=4'hF is acknowledged one cycle later with `bus_err`=0 and `bus_rdata`=0. It changes neither the count nor the status.
- R5: A request whose `bus_be` is not 4'hF, read or write, is answered one cycle later with `bus_ack`=1, `bus_err`=1 and `bus_rdata`=0. It has no other effect. Without a request, `bus_ack` is 0 in the next cycle.
- R6: `tmr_evt` is high for exactly the one cycle that follows a tick edge at which bit CNT_W-1 of the count changes. This covers both the 0-to-1 change and the 1-to-0 change at wrap-around.
- R7: `tmr_sts` becomes 1 in the cycle after `tmr_evt` and stays 1 until it is cleared.
- R8: `sts_clr` high at an edge clears `tmr_sts`, unless `tmr_evt` is high at that same edge, in which case the set wins. A clear while the status is already 0 changes nothing. After a clear, the status sets again only at the next event.
- R9: `wake_req` equals `tmr_evt` gated by `tmr_en`, and `sci_req` equals `tmr_sts` gated by `tmr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the count by one when high |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte strobes; only 4'hF is a legal access |
| bus_ack | output | 1 | Access answered (one cycle after request) |
| bus_err | output | 1 | Access was not a full-word access |
| bus_rdata | output | 32 | Zero-extended count on a legal read, else zero |
| tmr_en | input | 1 | Timer enable bit from the PM1 event logic |
| sts_clr | input | 1 | Software clear strobe for the timer status |
| tmr_evt | output | 1 | One-cycle pulse when the count's top bit changes |
| tmr_sts | output | 1 | Sticky timer status |
| wake_req | output | 1 | Wake pulse: event while enabled |
| sci_req | output | 1 | Interrupt level: status while enabled |

## Verification
The bench uses a narrow counter so that both directions of top-bit change occur many times in one run, including the wrap from all ones to zero. A design that fires only on carry-out would miss half of the events. A design that fires on every tick would flood the status. The bench holds the clear strobe high across an event to check that set beats clear. It also clears an already-clear status, and it checks that reads return the count as it stood at the request edge rather than one tick later. Writes and partial-strobe accesses are interleaved with reads, so any disturbance of the count shows up in the next read value.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int unsigned BUS_W = 32;
    localparam int unsigned BE_W  = BUS_W / 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_BAD   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic             ack;
        logic             err;
        logic [BUS_W-1:0] data;
    } bus_rsp_t;

    // Sort an incoming request: only full-word strobes are legal.
    function automatic acc_kind_e classify(input logic req, input logic we,
                                           input logic [BE_W-1:0] be);
        if (!req)
            return ACC_IDLE;
        else if (be != {BE_W{1'b1}})
            return ACC_BAD;
        else if (we)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             evt_o
);
    localparam int unsigned     TOP = CNT_W - 1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             evt_q;

    assign cnt_nxt = cnt_q + ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            // top bit flips in either direction, wrap included
            evt_q <= tick_en & (cnt_nxt[TOP] ^ cnt_q[TOP]);
            if (tick_en)
                cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;
    assign evt_o = evt_q;
endmodule

// File: rtl/pmt_status.sv
module pmt_status (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic clr_i,
    output logic sts_o
);
    logic sts_q;

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= 1'b0;
        else if (evt_i)
            sts_q <= 1'b1;      // a new event beats a clear in the same cycle
        else if (clr_i)
            sts_q <= 1'b0;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/pmt_bus_port.sv
module pmt_bus_port
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [BE_W-1:0]  be_i,
    input  logic [CNT_W-1:0] cnt_i,
    output bus_rsp_t         rsp_o
);
    acc_kind_e kind;
    bus_rsp_t  rsp_q;

    assign kind = classify(req_i, we_i, be_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.ack  <= (kind != ACC_IDLE);
            rsp_q.err  <= (kind == ACC_BAD);
            rsp_q.data <= (kind == ACC_READ) ? BUS_W'(cnt_i) : '0;
        end
    end

    assign rsp_o = rsp_q;
endmodule

// File: rtl/acpi_pm_timer.sv
module acpi_pm_timer
    import pmt_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [3:0]  bus_be,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [31:0] bus_rdata,
    input  logic        tmr_en,
    input  logic        sts_clr,
    output logic        tmr_evt,
    output logic        tmr_sts,
    output logic        wake_req,
    output logic        sci_req
);
    logic [CNT_W-1:0] cnt_w;
    logic             evt_w;
    logic             sts_w;
    bus_rsp_t         rsp_w;

    pmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_o   (cnt_w),
        .evt_o   (evt_w)
    );

    pmt_status u_sts (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_w),
        .clr_i (sts_clr),
        .sts_o (sts_w)
    );

    pmt_bus_port #(.CNT_W(CNT_W)) u_bus (
        .clk   (clk),
        .rst   (rst),
        .req_i (bus_req),
        .we_i  (bus_we),
        .be_i  (bus_be),
        .cnt_i (cnt_w),
        .rsp_o (rsp_w)
    );

    assign bus_ack   = rsp_w.ack;
    assign bus_err   = rsp_w.err;
    assign bus_rdata = rsp_w.data;
    assign tmr_evt   = evt_w;
    assign tmr_sts   = sts_w;
    assign wake_req  = evt_w & tmr_en;
    assign sci_req   = sts_w & tmr_en;
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic [CNT_W-1:0] cnt,
    input logic             evt,
    input logic             sts,
    input logic             sts_clr,
    input logic             bus_req,
    input logic [3:0]       bus_be,
    input logic             bus_ack,
    input logic             bus_err,
    input logic [31:0]      bus_rdata
);
    localparam logic [31:0]      LOW_MASK = 32'((64'd1 << CNT_W) - 64'd1);
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));                                        // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (cnt == $past(cnt) + ONE));                            // R2
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_ack);                                              // R3
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> ((bus_rdata & ~LOW_MASK) == 32'd0));                   // R3
    AST_BAD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_be != 4'hF) |=> (bus_err && bus_rdata == 32'd0));  // R5
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_ack);                                            // R5
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);                                                     // R6
    AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
        evt |=> sts);                                                      // R7
    AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sts && !sts_clr) |=> sts);                                        // R7
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !evt) |=> !sts);                                       // R8
endmodule

bind acpi_pm_timer pmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .cnt       (cnt_w),
    .evt       (evt_w),
    .sts       (sts_w),
    .sts_clr   (sts_clr),
    .bus_req   (bus_req),
    .bus_be    (bus_be),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata)
);

// File: tb/acpi_pm_timer_bench.sv
module acpi_pm_timer_bench;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic        bus_ack;
    logic        bus_err;
    logic [31:0] bus_rdata;
    logic        tmr_en = 1'b0;
    logic        sts_clr = 1'b0;
    logic        tmr_evt;
    logic        tmr_sts;
    logic        wake_req;
    logic        sci_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    acpi_pm_timer #(.CNT_W(W)) u_acpi_pm_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .tmr_en(tmr_en), .sts_clr(sts_clr),
        .tmr_evt(tmr_evt), .tmr_sts(tmr_sts),
        .wake_req(wake_req), .sci_req(sci_req)
    );

    // Behavioural reference, advanced at each rising edge.
    int m_cnt = 0;
    bit m_evt = 0, m_sts = 0, m_ack = 0, m_err = 0;
    int m_rd  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_evt = 0; m_sts = 0; m_ack = 0; m_err = 0; m_rd = 0;
        end else begin
            int nxt;
            bit new_evt;
            nxt     = (m_cnt + 1) & MASK;
            new_evt = tick_en && (((nxt >> (W-1)) & 1) != ((m_cnt >> (W-1)) & 1));
            if (m_evt)        m_sts = 1;
            else if (sts_clr) m_sts = 0;
            m_ack = bus_req;
            m_err = bus_req && (bus_be != 4'hF);
            m_rd  = (bus_req && !bus_we && bus_be == 4'hF) ? m_cnt : 0;
            if (tick_en) m_cnt = nxt;
            m_evt = new_evt;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            check(rst ? "R1" : "R3", "bus_ack", int'(bus_ack), int'(m_ack));
            check("R5", "bus_err",   int'(bus_err), int'(m_err));
            check("R3", "bus_rdata", int'(bus_rdata), m_rd);
            check("R6", "tmr_evt",   int'(tmr_evt), int'(m_evt));
            check(rst ? "R1" : "R7", "tmr_sts", int'(tmr_sts), int'(m_sts));
            check("R9", "wake_req",  int'(wake_req), int'(m_evt && tmr_en));
            check("R9", "sci_req",   int'(sci_req),  int'(m_sts && tmr_en));
        end
    end

    task automatic drive(input bit tk, input bit rq, input bit we, input logic [3:0] be,
                         input bit en, input bit clr);
        @(posedge clk);
        #2;
        tick_en = tk; bus_req = rq; bus_we = we; bus_be = be; tmr_en = en; sts_clr = clr;
    endtask

    // Single read with an explicit value check (R3).
    task automatic read_expect(input int exp, input string req);
        drive(1'b0, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);
        @(negedge clk);
        check(req, "directed read", int'(bus_rdata), exp);
    endtask

    initial begin
        // R1: reset state
        repeat (3) drive(1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0);
        @(negedge clk);
        check("R1", "rdata in reset", int'(bus_rdata), 0);
        check("R1", "sts in reset", int'(tmr_sts), 0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0);
        rst = 1'b0;
        read_expect(0, "R1");

        // R2/R6/R7: steady ticks through several top-bit changes and wraps
        for (int i = 0; i < 700; i++)
            drive(1'b1, (i % 3) == 0, 1'b0, 4'hF, 1'b1, 1'b0);

        // R8: clear held high across events, then clear while clear
        for (int i = 0; i < 300; i++)
            drive(1'b1, (i % 5) == 0, 1'b0, 4'hF, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++)
            drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b0, (i % 2) == 0);

        // R4: writes do not disturb count or status
        read_expect(1000 & MASK, "R4");
        for (int i = 0; i < 10; i++)
            drive(1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0);
        read_expect(1000 & MASK, "R4");

        // R5: partial strobes rejected, no effect
        drive(1'b0, 1'b1, 1'b0, 4'h1, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 4'h7, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);
        @(negedge clk);
        check("R5", "err after bad write", int'(bus_err), 1);
        read_expect(1000 & MASK, "R5");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            drive(r < 60, (r % 3) == 0, (r % 7) == 0, (r % 11) == 0 ? 4'h3 : 4'hF,
                  (r % 13) != 0, (r % 17) == 0);
        end

        // R1: mid-run reset
        drive(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);
        rst = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0);
        read_expect(1, "R1");

        drive(1'b0, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule